// File: doc/BRIEF.md
# Converter Power-Mode Sequencer

This controller turns two static mode pins, a power-down select and a converter enable, into one of four operating states for a dual data converter. The four states are off, idle, waking and running. It drives separate enables for the voltage reference, the control amplifier and the output current array. It also tells the analog output stage whether to drive the held codes, float, or tie to ground. A ready flag goes high only after a wake-up interval has elapsed. That interval is counted in clock cycles from a clock-rate parameter.

The wait depends on where the wake-up started. Leaving idle, where the reference and amplifier are still biased, costs a short interval. Leaving off, where everything must settle again, costs a long one. If the pins change while the wait is counting, the count is dropped and the newly requested state is entered on the next edge. The mode pins are assumed to be already synchronous to the clock.

Top module: `pwr_mode_seq`

## Requirements
- R1: After a synchronous active-low reset the block is off: reference, amplifier and array enables low, output drive low, ready low.
- R2: A high power-down pin selects off at the next clock edge whatever the enable pin is; in off all three enables and ready are low.
- R3: Power-down low with enable low selects idle at the next edge: reference and amplifier enables high, array enable and ready low.
- R4: In off and idle the output-state control asks for high impedance (out_hiz_o=1, out_gnd_o=0) when VOLTAGE_OUT=0 and for ground (out_gnd_o=1, out_hiz_o=0) when VOLTAGE_OUT=1; while waking or running out_drive_o=1 and the other two are 0; exactly one of the three is high at any time.
- R5: Requesting run (power-down low, enable high) from idle raises all three enables at the next edge, and ready rises exactly IDLE_CYC edges after that one, where IDLE_CYC = ceil(CLK_MHZ*IDLE_WAKE_NS/1000), minimum 1 (20 at defaults).
- R6: Requesting run from off starts the same wake sequence with OFF_CYC = ceil(CLK_MHZ*OFF_WAKE_NS/1000), minimum 1 (2000 at defaults), before ready rises.
- R7: A pin change away from run during the wake wait enters the requested state at the next edge with ready low; a later run request waits the full interval again.
- R8: From running, a request for idle or off takes effect at the next edge, and ready drops at that same edge.
- R9: While the pins keep requesting run, the running state and ready persist unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_down_i | input | 1 | Power-down select, high forces off |
| conv_en_i | input | 1 | Converter enable, high requests run when not powered down |
| ref_en_o | output | 1 | Voltage reference enable |
| amp_en_o | output | 1 | Control amplifier enable |
| array_en_o | output | 1 | Output current array enable |
| out_drive_o | output | 1 | Outputs drive the held codes |
| out_hiz_o | output | 1 | Outputs float (current-output variant, low-power states) |
| out_gnd_o | output | 1 | Outputs tie to ground (voltage-output variant, low-power states) |
| ready_o | output | 1 | Wake-up interval complete, outputs valid |

## Verification
A wrong state register shows at the ports one edge after the pins that set it, as an illegal mix of enables: for example the array on without the reference, or more than one output-state line high. A wrong wait count is seen only where ready rises. It is early or late against the interval the bench computes from the clock rate, up to 2000 cycles after an exit from off. A missed abort leaves the array enabled one edge after the pins leave run.

// File: rtl/pwr_mode_pkg.sv
// Shared types for the power-mode sequencer.
// Assumes: two-bit state encoding is sufficient for the four modes.
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        PM_OFF  = 2'd0,
        PM_IDLE = 2'd1,
        PM_WAKE = 2'd2,
        PM_RUN  = 2'd3
    } pm_state_t;

endpackage

// File: rtl/pwr_mode_decode.sv
// Maps the two mode pins to a requested steady state.
// Assumes: pins are synchronous to the clock; power-down has priority.
module pwr_mode_decode
    import pwr_mode_pkg::*;
(
    input  logic      pwr_down,
    input  logic      conv_en,
    output pm_state_t req
);

    // Priority decode: power-down wins, then enable picks run or idle.
    always_comb begin
        if (pwr_down) begin
            req = PM_OFF;
        end else if (conv_en) begin
            req = PM_RUN;
        end else begin
            req = PM_IDLE;
        end
    end

endmodule

// File: rtl/pwr_wake_timer.sv
// Down-counter for the wake-up interval.
// Assumes: load has priority over counting; done means count is zero.
module pwr_wake_timer #(
    parameter int SHORT_CYC = 20,
    parameter int LONG_CYC  = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic sel_long,
    input  logic run,
    output logic done
);

    localparam int CW = $clog2(LONG_CYC + 1);
    localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_CYC - 1);
    localparam logic [CW-1:0] LONG_LD  = CW'(LONG_CYC - 1);

    logic [CW-1:0] count;

    // Load the chosen interval, otherwise step toward zero while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= sel_long ? LONG_LD : SHORT_LD;
        end else if (run && (count != '0)) begin
            count <= count - 1'b1;
        end
    end

    // Expiry flag.
    always_comb begin
        done = (count == '0);
    end

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LONG_LD); // R6

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && done) |=> done); // R5

endmodule

// File: rtl/pwr_mode_fsm.sv
// Four-state power sequencer: off, idle, waking, running.
// Assumes: the request is a steady state (off, idle or run); a wake wait
// is short from idle and long from off, and any request change aborts it.
module pwr_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pm_state_t req,
    input  logic      tmr_done,
    output logic      tmr_load,
    output logic      tmr_long,
    output logic      tmr_run,
    output pm_state_t state
);

    pm_state_t state_nx;

    // Next-state and timer-load selection.
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_long = 1'b0;
        unique case (state)
            PM_OFF: begin
                if (req == PM_RUN) begin
                    state_nx = PM_WAKE;
                    tmr_load = 1'b1;
                    tmr_long = 1'b1;
                end else begin
                    state_nx = req;
                end
            end
            PM_IDLE: begin
                if (req == PM_RUN) begin
                    state_nx = PM_WAKE;
                    tmr_load = 1'b1;
                end else begin
                    state_nx = req;
                end
            end
            PM_WAKE: begin
                if (req != PM_RUN) begin
                    state_nx = req;
                end else if (tmr_done) begin
                    state_nx = PM_RUN;
                end
            end
            PM_RUN: begin
                state_nx = req;
            end
            default: state_nx = PM_OFF;
        endcase
    end

    // Timer counts only while waiting.
    always_comb begin
        tmr_run = (state == PM_WAKE);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PM_OFF;
        end else begin
            state <= state_nx;
        end
    end

    AST_ABORT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_WAKE && req != PM_RUN) |=> state == $past(req)); // R7

    AST_RUN_VIA_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_RUN && $past(state) != PM_RUN) |-> $past(state) == PM_WAKE); // R5

    AST_WAKE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_WAKE && $past(state) != PM_WAKE)
            |-> ($past(state) == PM_OFF || $past(state) == PM_IDLE)); // R6

endmodule

// File: rtl/pwr_out_map.sv
// Maps the sequencer state to block enables and the output-state control.
// Assumes: VOLTAGE_OUT selects grounded outputs in low-power states,
// otherwise the outputs float there.
module pwr_out_map
    import pwr_mode_pkg::*;
#(
    parameter bit VOLTAGE_OUT = 1'b0
) (
    input  pm_state_t state,
    output logic      ref_en,
    output logic      amp_en,
    output logic      array_en,
    output logic      out_drive,
    output logic      out_hiz,
    output logic      out_gnd,
    output logic      ready
);

    logic low_pwr;

    // Enables per state.
    always_comb begin
        ref_en    = (state != PM_OFF);
        amp_en    = (state != PM_OFF);
        array_en  = (state == PM_WAKE) || (state == PM_RUN);
        out_drive = array_en;
        ready     = (state == PM_RUN);
        low_pwr   = !array_en;
    end

    generate
        if (VOLTAGE_OUT) begin : g_vout
            assign out_gnd = low_pwr;
            assign out_hiz = 1'b0;
        end else begin : g_iout
            assign out_hiz = low_pwr;
            assign out_gnd = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/pwr_mode_seq.sv
// Top of the converter power-mode sequencer.
// Assumes: clock rate given in whole MHz; mode pins already synchronous.
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int CLK_MHZ      = 40,
    parameter int IDLE_WAKE_NS = 500,
    parameter int OFF_WAKE_NS  = 50000,
    parameter bit VOLTAGE_OUT  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down_i,
    input  logic conv_en_i,
    output logic ref_en_o,
    output logic amp_en_o,
    output logic array_en_o,
    output logic out_drive_o,
    output logic out_hiz_o,
    output logic out_gnd_o,
    output logic ready_o
);

    localparam int IDLE_RAW = (CLK_MHZ * IDLE_WAKE_NS + 999) / 1000;
    localparam int OFF_RAW  = (CLK_MHZ * OFF_WAKE_NS + 999) / 1000;
    localparam int IDLE_CYC = (IDLE_RAW < 1) ? 1 : IDLE_RAW;
    localparam int OFF_CYC  = (OFF_RAW < IDLE_CYC) ? IDLE_CYC : OFF_RAW;

    pm_state_t req;
    pm_state_t state;
    logic      tmr_load;
    logic      tmr_long;
    logic      tmr_run;
    logic      tmr_done;

    pwr_mode_decode u_decode (
        .pwr_down (pwr_down_i),
        .conv_en  (conv_en_i),
        .req      (req)
    );

    pwr_wake_timer #(
        .SHORT_CYC (IDLE_CYC),
        .LONG_CYC  (OFF_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .sel_long (tmr_long),
        .run      (tmr_run),
        .done     (tmr_done)
    );

    pwr_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .tmr_done (tmr_done),
        .tmr_load (tmr_load),
        .tmr_long (tmr_long),
        .tmr_run  (tmr_run),
        .state    (state)
    );

    pwr_out_map #(
        .VOLTAGE_OUT (VOLTAGE_OUT)
    ) u_map (
        .state     (state),
        .ref_en    (ref_en_o),
        .amp_en    (amp_en_o),
        .array_en  (array_en_o),
        .out_drive (out_drive_o),
        .out_hiz   (out_hiz_o),
        .out_gnd   (out_gnd_o),
        .ready     (ready_o)
    );

    AST_OFF_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down_i |=> (!ref_en_o && !amp_en_o && !array_en_o && !ready_o)); // R2

    AST_IDLE_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_down_i && !conv_en_i) |=> (ref_en_o && amp_en_o && !array_en_o && !ready_o)); // R3

    AST_OUT_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({out_drive_o, out_hiz_o, out_gnd_o}) == 1); // R4

    AST_READY_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> $past(!pwr_down_i && conv_en_i)); // R8

    AST_READY_BIASED: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (ref_en_o && amp_en_o && array_en_o)); // R5

    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !pwr_down_i && conv_en_i) |=> ready_o); // R9

endmodule

// File: tb/pwr_mode_seq_bench.sv
// Directed bench for the power-mode sequencer, one task per scenario.
module pwr_mode_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MHZ        = 40;
    localparam int IDLE_CYC   = (MHZ * 500 + 999) / 1000;
    localparam int OFF_CYC    = (MHZ * 50000 + 999) / 1000;

    // Output vector order: ref, amp, array, drive, hiz, gnd, ready
    localparam logic [6:0] V_OFF  = 7'b000_0_1_0_0;
    localparam logic [6:0] V_IDLE = 7'b110_0_1_0_0;
    localparam logic [6:0] V_WAKE = 7'b111_1_0_0_0;
    localparam logic [6:0] V_RUN  = 7'b111_1_0_0_1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_down = 1'b1;
    logic conv_en = 1'b0;
    logic ref_en, amp_en, array_en, out_drive, out_hiz, out_gnd, ready;
    logic v_ref, v_amp, v_arr, v_drive, v_hiz, v_gnd, v_ready;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwr_mode_seq u_pwr_mode_seq (
        .clk (clk), .rst_n (rst_n), .pwr_down_i (pwr_down), .conv_en_i (conv_en),
        .ref_en_o (ref_en), .amp_en_o (amp_en), .array_en_o (array_en),
        .out_drive_o (out_drive), .out_hiz_o (out_hiz), .out_gnd_o (out_gnd),
        .ready_o (ready)
    );

    pwr_mode_seq #(.VOLTAGE_OUT (1'b1)) u_pwr_mode_seq_vout (
        .clk (clk), .rst_n (rst_n), .pwr_down_i (pwr_down), .conv_en_i (conv_en),
        .ref_en_o (v_ref), .amp_en_o (v_amp), .array_en_o (v_arr),
        .out_drive_o (v_drive), .out_hiz_o (v_hiz), .out_gnd_o (v_gnd),
        .ready_o (v_ready)
    );

    function automatic logic [6:0] outs();
        return {ref_en, amp_en, array_en, out_drive, out_hiz, out_gnd, ready};
    endfunction

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Pins change at a falling edge; step(n) passes n rising edges.
    task automatic pins(input logic pd, input logic en);
        pwr_down = pd;
        conv_en  = en;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        pins(1'b0, 1'b1);
        rst_n = 1'b0;
        step(3);
        check("R1 reset state", outs(), V_OFF);
        rst_n = 1'b1;
        pins(1'b1, 1'b0);
        step(1);
        check("R1 off after release", outs(), V_OFF);
    endtask

    task automatic t_idle_and_outputs();
        pins(1'b0, 1'b0);
        step(1);
        check("R3 idle enables", outs(), V_IDLE);
        check("R4 ground variant idle", {v_ref, v_amp, v_arr, v_drive, v_hiz, v_gnd, v_ready},
              7'b110_0_0_1_0);
        pins(1'b1, 1'b0);
        step(1);
        check("R2 off from idle", outs(), V_OFF);
        check("R4 ground variant off", {v_ref, v_amp, v_arr, v_drive, v_hiz, v_gnd, v_ready},
              7'b000_0_0_1_0);
    endtask

    task automatic t_wake_from_idle();
        pins(1'b0, 1'b0);
        step(2);
        pins(1'b0, 1'b1);
        step(1);
        check("R5 waking enables", outs(), V_WAKE);
        check("R4 ground variant waking", {v_ref, v_amp, v_arr, v_drive, v_hiz, v_gnd, v_ready},
              7'b111_1_0_0_0);
        step(IDLE_CYC - 1);
        check("R5 ready not before short wait", outs(), V_WAKE);
        step(1);
        check("R5 ready after short wait", outs(), V_RUN);
        step(50);
        check("R9 run persists", outs(), V_RUN);
        pins(1'b0, 1'b0);
        step(1);
        check("R8 run to idle", outs(), V_IDLE);
    endtask

    task automatic t_wake_from_off();
        pins(1'b1, 1'b1);
        step(2);
        check("R2 off with enable high", outs(), V_OFF);
        pins(1'b0, 1'b1);
        step(1);
        check("R6 waking from off", outs(), V_WAKE);
        step(IDLE_CYC);
        check("R6 short wait not used from off", outs(), V_WAKE);
        step(OFF_CYC - 1 - IDLE_CYC);
        check("R6 ready not before long wait", outs(), V_WAKE);
        step(1);
        check("R6 ready after long wait", outs(), V_RUN);
        pins(1'b1, 1'b1);
        step(1);
        check("R8 run to off", outs(), V_OFF);
    endtask

    task automatic t_abort();
        pins(1'b0, 1'b0);
        step(1);
        pins(1'b0, 1'b1);
        step(5);
        pins(1'b0, 1'b0);
        step(1);
        check("R7 abort to idle", outs(), V_IDLE);
        pins(1'b0, 1'b1);
        step(IDLE_CYC);
        check("R7 restart full short wait", outs(), V_WAKE);
        step(1);
        check("R7 ready after restart", outs(), V_RUN);
        pins(1'b1, 1'b0);
        step(1);
        pins(1'b0, 1'b1);
        step(100);
        pins(1'b1, 1'b1);
        step(1);
        check("R7 abort long wait to off", outs(), V_OFF);
        pins(1'b0, 1'b1);
        step(OFF_CYC);
        check("R7 restart full long wait", outs(), V_WAKE);
        step(1);
        check("R7 ready after long restart", outs(), V_RUN);
    endtask

    initial begin
        step(1);
        t_reset();
        t_idle_and_outputs();
        t_wake_from_idle();
        t_wake_from_off();
        t_abort();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule